// File: doc/BRIEF.md
# Three-Level PWM Input Classifier

This block takes a stream of digitized voltage samples, in millivolts, from a PWM control pin and sorts each valid sample into one of three levels: low, high, or mid-level (tri-state). The mid-level region has separate entry thresholds for each side. A sample between those thresholds keeps whatever level was last decided. The same voltage can therefore read as low when approached from below and as mid-level when approached from above. This hysteresis keeps noise near a boundary from producing false transitions. The default thresholds suit 3.3 V logic swings, and a pin left floating settles inside the mid-level band.

Downstream logic, typically a gate-drive sequencer that owns all hold-off timing, reads a registered two-bit level code. It also receives a one-cycle strobe whenever that code changes. The block keeps no timers. It keeps only the current level.

Top module: `pwm_level_sorter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the level code reads TRI (2'b10) and the change strobe is 0.
- R2: A valid sample strictly above HI_RISE_MV (default 2400) gives HIGH (2'b01) on the clock edge that captures it, whatever the current level.
- R3: A valid sample strictly below LO_FALL_MV (default 900) gives LOW (2'b00) on the capturing edge, whatever the current level.
- R4: From LOW, a valid sample strictly above MID_RISE_MV (default 1200) and not above HI_RISE_MV gives TRI. A sample at or below MID_RISE_MV keeps LOW.
- R5: From HIGH, a valid sample strictly below MID_FALL_MV (default 2200) and not below LO_FALL_MV gives TRI. A sample at or above MID_FALL_MV keeps HIGH.
- R6: From TRI, any valid sample from LO_FALL_MV up to HI_RISE_MV inclusive keeps TRI. A floating-pin level of 1800 mV yields TRI from every starting level.
- R7: Samples presented while the valid strobe is low have no effect on the level code or the change strobe.
- R8: The level code uses 2'b00 = LOW, 2'b01 = HIGH and 2'b10 = TRI, and never reads 2'b11.
- R9: The change strobe is 1 for exactly the one cycle in which the level code first shows a new value. It is 0 in every other cycle, including after a valid sample that confirms the current level.
- R10: Every threshold compare is strict. A sample equal to a threshold does not cross that threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_mv_i | input | SAMPLE_W | Unsigned sample voltage in millivolts |
| lvl_o | output | 2 | Registered level code (00 LOW, 01 HIGH, 10 TRI) |
| lvl_chg_o | output | 1 | One-cycle pulse when lvl_o changes |

## Verification
The only internal state is the current level, and every valid sample exposes it on lvl_o one edge after capture. The stimulus therefore puts the block in each starting level and then applies samples inside the hysteresis bands. In those bands a wrong stored level shows up at once as the wrong code, for example 1000 mV reading TRI where LOW was expected. The change strobe is checked on the capture cycle and again on the following idle cycle, so a stuck or stretched pulse is seen within one cycle.

// File: rtl/pwm_level_pkg.sv
package pwm_level_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_TRI  = 2'b10
  } lvl_e;

  // index of each threshold compare in the comparator bank
  localparam int unsigned CMP_HI   = 0;
  localparam int unsigned CMP_LO   = 1;
  localparam int unsigned CMP_MIDR = 2;
  localparam int unsigned CMP_MIDF = 3;
  localparam int unsigned CMP_N    = 4;

endpackage

// File: rtl/pwm_thr_cmp.sv
module pwm_thr_cmp #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned THR_MV   = 0,
  parameter bit          ABOVE    = 1'b1
) (
  input  logic [SAMPLE_W-1:0] smp_i,
  output logic                hit_o
);

  localparam logic [SAMPLE_W-1:0] THR_V = SAMPLE_W'(THR_MV);

  generate
    if (ABOVE) begin : g_above
      assign hit_o = (smp_i > THR_V);
    end else begin : g_below
      assign hit_o = (smp_i < THR_V);
    end
  endgenerate

endmodule

// File: rtl/pwm_lvl_next.sv
module pwm_lvl_next
  import pwm_level_pkg::*;
(
  input  lvl_e              cur_i,
  input  logic [CMP_N-1:0]  hit_i,
  output lvl_e              nxt_i
);

  always_comb begin
    nxt_i = cur_i;
    if (hit_i[CMP_HI]) begin
      nxt_i = LVL_HIGH;
    end else if (hit_i[CMP_LO]) begin
      nxt_i = LVL_LOW;
    end else if (cur_i == LVL_LOW && hit_i[CMP_MIDR]) begin
      nxt_i = LVL_TRI;
    end else if (cur_i == LVL_HIGH && hit_i[CMP_MIDF]) begin
      nxt_i = LVL_TRI;
    end
  end

endmodule

// File: rtl/pwm_level_sorter.sv
module pwm_level_sorter
  import pwm_level_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 12,
  parameter int unsigned HI_RISE_MV  = 2400,
  parameter int unsigned LO_FALL_MV  = 900,
  parameter int unsigned MID_RISE_MV = 1200,
  parameter int unsigned MID_FALL_MV = 2200
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_vld_i,
  input  logic [SAMPLE_W-1:0] smp_mv_i,
  output logic [1:0]          lvl_o,
  output logic                lvl_chg_o
);

  localparam int unsigned THR_TAB [CMP_N] = '{HI_RISE_MV, LO_FALL_MV, MID_RISE_MV, MID_FALL_MV};
  localparam bit          DIR_TAB [CMP_N] = '{1'b1, 1'b0, 1'b1, 1'b0};

  logic [CMP_N-1:0] hit;
  lvl_e             lvl_q;
  lvl_e             lvl_nxt;

  generate
    for (genvar gi = 0; gi < CMP_N; gi++) begin : g_cmp
      pwm_thr_cmp #(
        .SAMPLE_W (SAMPLE_W),
        .THR_MV   (THR_TAB[gi]),
        .ABOVE    (DIR_TAB[gi])
      ) u_cmp (
        .smp_i (smp_mv_i),
        .hit_o (hit[gi])
      );
    end
  endgenerate

  pwm_lvl_next u_next (
    .cur_i (lvl_q),
    .hit_i (hit),
    .nxt_i (lvl_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q     <= LVL_TRI;
      lvl_chg_o <= 1'b0;
    end else if (smp_vld_i) begin
      lvl_q     <= lvl_nxt;
      lvl_chg_o <= (lvl_nxt != lvl_q);
    end else begin
      lvl_chg_o <= 1'b0;
    end
  end

  assign lvl_o = lvl_q;

  // R2
  hi_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld_i && smp_mv_i > SAMPLE_W'(HI_RISE_MV)) |=> (lvl_o == 2'b01));

  // R3
  lo_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld_i && smp_mv_i < SAMPLE_W'(LO_FALL_MV)) |=> (lvl_o == 2'b00));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld_i |=> ($stable(lvl_o) && !lvl_chg_o));

  // R8
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_o != 2'b11);

  // R9
  chg_marks_move_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_chg_o |-> (lvl_o != $past(lvl_o)));

  // R9
  move_marks_chg_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_o != $past(lvl_o)) |-> lvl_chg_o);

endmodule

// File: tb/pwm_level_sorter_bench.sv
`timescale 1ns/1ps
module pwm_level_sorter_bench;

  localparam int unsigned SW = 12;
  localparam logic [1:0] LO = 2'b00;
  localparam logic [1:0] HI = 2'b01;
  localparam logic [1:0] TR = 2'b10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vld = 1'b0;
  logic [SW-1:0] smp = '0;
  logic [1:0]    lvl;
  logic          chg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pwm_level_sorter #(.SAMPLE_W(SW)) u_pwm_level_sorter (
    .clk       (clk),
    .rst       (rst),
    .smp_vld_i (vld),
    .smp_mv_i  (smp),
    .lvl_o     (lvl),
    .lvl_chg_o (chg)
  );

  task automatic cmp(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one valid sample, check capture cycle and the idle cycle after it (R9)
  task automatic step(input int mv, input logic [1:0] e_lvl, input logic e_chg,
                      input string req);
    @(negedge clk);
    smp = SW'(mv);
    vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    cmp(req, lvl, e_lvl);
    cmp({req, " strobe"}, chg, e_chg);
    @(negedge clk);
    cmp("R9 pulse ends", chg, 0);
    cmp("R9 level held", lvl, e_lvl);
  endtask

  task automatic t_reset();
    @(negedge clk);
    cmp("R1 level in reset", lvl, TR);
    cmp("R1 strobe in reset", chg, 0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 level after reset", lvl, TR);
    cmp("R1 strobe after reset", chg, 0);
    cmp("R8 code legal", int'(lvl != 2'b11), 1);
  endtask

  task automatic t_ramp_up();
    step(500,  LO, 1'b1, "R3 TRI to LOW");
    step(1000, LO, 1'b0, "R4 1000 from LOW stays LOW");
    step(1200, LO, 1'b0, "R10 MID_RISE equal stays LOW");
    step(1201, TR, 1'b1, "R4 above MID_RISE gives TRI");
    step(2400, TR, 1'b0, "R10 HI_RISE equal keeps TRI");
    step(2401, HI, 1'b1, "R2 above HI_RISE gives HIGH");
    step(3000, HI, 1'b0, "R9 same level no strobe");
  endtask

  task automatic t_ramp_down();
    step(2200, HI, 1'b0, "R10 MID_FALL equal stays HIGH");
    step(2199, TR, 1'b1, "R5 below MID_FALL gives TRI");
    step(1000, TR, 1'b0, "R6 1000 from TRI stays TRI");
    step(3300, HI, 1'b1, "R2 TRI to HIGH");
    step(1000, TR, 1'b1, "R5 1000 from HIGH gives TRI");
    step(900,  TR, 1'b0, "R10 LO_FALL equal keeps TRI");
    step(899,  LO, 1'b1, "R3 below LO_FALL gives LOW");
  endtask

  task automatic t_float();
    step(1800, TR, 1'b1, "R6 float from LOW");
    step(1800, TR, 1'b0, "R6 float from TRI");
    step(2500, HI, 1'b1, "R2 prep HIGH");
    step(1800, TR, 1'b1, "R6 float from HIGH");
  endtask

  task automatic t_ignore();
    step(0, LO, 1'b1, "R3 prep LOW");
    @(negedge clk);
    smp = SW'(3500);
    vld = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cmp("R7 ignored sample level", lvl, LO);
      cmp("R7 ignored sample strobe", chg, 0);
    end
    step(4000, HI, 1'b1, "R2 LOW to HIGH direct");
    step(0,    LO, 1'b1, "R3 HIGH to LOW direct");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_ramp_up();
    t_ramp_down();
    t_float();
    t_ignore();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule